// File: doc/BRIEF.md
# Asynchronous SRAM Controller with Byte Lanes

This block sits between a clocked host and an external asynchronous static RAM that is 16 bits wide and 131,072 words deep. The host issues one single-word read or write at a time over a valid/ready handshake. Each request carries a word address, write data and one enable bit per byte lane. The controller turns each request into a memory cycle. It drives an active-low chip select, an active-high second chip select, active-low output enable and write enable, and one active-low strobe per byte lane. It also controls the bidirectional data bus through a separate output value, input value and driver enable.

All memory-side outputs come straight from registers. The address is placed on the pins one clock before the chip is selected, and it never moves while the chip is selected. Cycle lengths come from two integer parameters. Each is the memory's nanosecond limit divided by the clock period and rounded up: for example 6 read clocks and 5 write-enable clocks at 100 MHz. `WE_CYCLES` must be at least 2, so that driven data overlaps the end of the write. Reads return the sampled word with a one-clock valid pulse. A request with no byte enabled is retired at once and never touches the memory.

Top module: `asram_ctrl`

## Requirements
- R1: After reset the memory is deselected: `sram_ce_n`=1, `sram_ce2`=0, `sram_oe_n`=1, `sram_we_n`=1, `sram_bs_n`=2'b11, `sram_dq_oe`=0. On the host side `req_ready`=1 and `rd_valid`=0.
- R2: `sram_addr` takes the new address one clock before `sram_ce_n` falls. It holds that value for every clock in which `sram_ce_n` is low.
- R3: A read holds `sram_ce_n`=0, `sram_ce2`=1, `sram_oe_n`=0 and `sram_we_n`=1 for exactly READ_CYCLES clocks. During those clocks `sram_bs_n[i]` is the inverse of the request's `req_be[i]`: bit 0 is the lower lane, data bits 7:0, and bit 1 is the upper lane, bits 15:8. The data bus is sampled at the clock edge that ends the last of those clocks.
- R4: In `rd_data`, a lane whose enable bit was 0 reads as zero, whatever the bus carried.
- R5: A write holds `sram_we_n`=0 for exactly WE_CYCLES clocks. For the whole of that time `sram_ce_n`=0, `sram_ce2`=1 and `sram_bs_n`=~`req_be`. Write enable, chip selects and strobes all release on the same edge.
- R6: `sram_oe_n` stays 1 for the whole of a write cycle, and is never 0 while `sram_we_n` is 0.
- R7: `sram_dq_oe` rises one clock after `sram_we_n` falls and falls one clock after `sram_we_n` rises. While it is 1, `sram_dq_o` carries the request's write data.
- R8: `req_ready` is 1 only when the controller is idle. Take the accepting clock edge as edge 0. For a read, `rd_valid` is high in the cycle after edge READ_CYCLES+1. For a write, `req_ready` returns in the cycle after edge WE_CYCLES+2.
- R9: A request with `req_be`=2'b00 causes no memory pin activity, and `req_ready` stays 1. For a read, `rd_valid` is high with `rd_data`=0 in the cycle after the accepting edge.
- R10: Each read request produces `rd_valid` for exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request is taken on this clock |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 lower lane, bit 1 upper lane |
| rd_data | output | 16 | Read data, disabled lanes zero |
| rd_valid | output | 1 | One-clock read completion pulse |
| sram_addr | output | 17 | Memory address |
| sram_ce_n | output | 1 | Active-low chip select |
| sram_ce2 | output | 1 | Active-high second chip select |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_we_n | output | 1 | Active-low write enable |
| sram_bs_n | output | 2 | Active-low byte strobes, bit 0 lower lane |
| sram_dq_o | output | 16 | Data driven toward the memory |
| sram_dq_i | input | 16 | Data returned from the memory bus |
| sram_dq_oe | output | 1 | Data bus driver enable |

## Verification
The bench's memory model returns junk on the bus until the read has lasted READ_CYCLES clocks. A controller that samples one clock early therefore returns wrong data. A controller that skips the address lead-in clock, or moves the address while selected, trips the address-stability check. The bench times the bus driver against write enable, so drivers that turn on in the same clock as write enable, or release on the same edge, are caught. So are write data that never reaches the bus (the readback differs) and output enable that drops during a write. Partial-lane writes and reads are mixed with untouched initial contents at the lowest and highest addresses. These expose a swapped lane, a lane that is not zeroed on read, and a strobe that does not follow its enable bit. Zero-enable requests check that nothing at all moves on the memory pins.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_READ  = 3'd2,
        ST_WRITE = 3'd3,
        ST_RECOV = 3'd4
    } seq_state_e;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_wait_cnt.sv
module asram_wait_cnt #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);

    // A loaded count never grows until the next load
    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load) && $past(cnt_q) == '0) |-> cnt_q == '0); // R5

endmodule

// File: rtl/asram_lanes.sv
module asram_lanes #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic [LANES-1:0]        lane_en,
    input  logic [LANES*LANE_W-1:0] bus_in,
    output logic [LANES-1:0]        strobe_n,
    output logic [LANES*LANE_W-1:0] bus_masked
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign strobe_n[g] = ~lane_en[g];
        assign bus_masked[g*LANE_W +: LANE_W] =
            lane_en[g] ? bus_in[g*LANE_W +: LANE_W] : '0;
    end

endmodule

// File: rtl/asram_seq.sv
module asram_seq
    import asram_pkg::*;
#(
    parameter int ADDR_W      = 17,
    parameter int DATA_W      = 16,
    parameter int LANES       = 2,
    parameter int READ_CYCLES = 6,
    parameter int WE_CYCLES   = 5,
    parameter int CNT_W       = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [LANES-1:0]  cur_be,
    input  logic [LANES-1:0]  lane_strobe_n,
    input  logic [DATA_W-1:0] lane_rdata,
    output logic              cnt_load,
    output logic [CNT_W-1:0]  cnt_val,
    input  logic              cnt_zero,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_ce2,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [LANES-1:0]  sram_bs_n,
    output logic [DATA_W-1:0] sram_dq_o,
    output logic              sram_dq_oe
);

    localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(READ_CYCLES - 1);
    localparam logic [CNT_W-1:0] WE_LOAD = CNT_W'(WE_CYCLES - 1);
    localparam logic [CNT_W:0]   RD_FULL = (CNT_W+1)'(READ_CYCLES);
    localparam logic [CNT_W:0]   WE_FULL = (CNT_W+1)'(WE_CYCLES);

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  be;
        logic              we_op;
        logic              ce_n;
        logic              ce2;
        logic              oe_n;
        logic              we_n;
        logic [LANES-1:0]  bs_n;
        logic              dq_oe;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } seq_reg_t;

    localparam seq_reg_t RESET_VAL = '{
        st:     ST_IDLE,
        addr:   '0,
        wdata:  '0,
        be:     '0,
        we_op:  1'b0,
        ce_n:   1'b1,
        ce2:    1'b0,
        oe_n:   1'b1,
        we_n:   1'b1,
        bs_n:   '1,
        dq_oe:  1'b0,
        rdata:  '0,
        rvalid: 1'b0
    };

    seq_reg_t r_d;
    seq_reg_t r_q;

    always_comb begin
        r_d        = r_q;
        r_d.rvalid = 1'b0;
        cnt_load   = 1'b0;
        cnt_val    = '0;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_be == '0) begin
                        if (!req_we) begin
                            r_d.rvalid = 1'b1;
                            r_d.rdata  = '0;
                        end
                    end else begin
                        r_d.st    = ST_ADDR;
                        r_d.addr  = req_addr;
                        r_d.wdata = req_wdata;
                        r_d.be    = req_be;
                        r_d.we_op = req_we;
                    end
                end
            end
            ST_ADDR: begin
                r_d.ce_n = 1'b0;
                r_d.ce2  = 1'b1;
                r_d.bs_n = lane_strobe_n;
                cnt_load = 1'b1;
                if (r_q.we_op) begin
                    r_d.st   = ST_WRITE;
                    r_d.we_n = 1'b0;
                    cnt_val  = WE_LOAD;
                end else begin
                    r_d.st   = ST_READ;
                    r_d.oe_n = 1'b0;
                    cnt_val  = RD_LOAD;
                end
            end
            ST_READ: begin
                if (cnt_zero) begin
                    r_d.rdata  = lane_rdata;
                    r_d.rvalid = 1'b1;
                    r_d.ce_n   = 1'b1;
                    r_d.ce2    = 1'b0;
                    r_d.oe_n   = 1'b1;
                    r_d.bs_n   = '1;
                    r_d.st     = ST_IDLE;
                end
            end
            ST_WRITE: begin
                r_d.dq_oe = 1'b1;
                if (cnt_zero) begin
                    r_d.we_n = 1'b1;
                    r_d.ce_n = 1'b1;
                    r_d.ce2  = 1'b0;
                    r_d.bs_n = '1;
                    r_d.st   = ST_RECOV;
                end
            end
            ST_RECOV: begin
                r_d.dq_oe = 1'b0;
                r_d.st    = ST_IDLE;
            end
            default: begin
                r_d = RESET_VAL;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= RESET_VAL;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready  = (r_q.st == ST_IDLE);
    assign rd_data    = r_q.rdata;
    assign rd_valid   = r_q.rvalid;
    assign cur_be     = r_q.be;
    assign sram_addr  = r_q.addr;
    assign sram_ce_n  = r_q.ce_n;
    assign sram_ce2   = r_q.ce2;
    assign sram_oe_n  = r_q.oe_n;
    assign sram_we_n  = r_q.we_n;
    assign sram_bs_n  = r_q.bs_n;
    assign sram_dq_o  = r_q.wdata;
    assign sram_dq_oe = r_q.dq_oe;

    // Window-length trackers used only by the checks below
    logic [CNT_W:0] we_lo_q;
    logic [CNT_W:0] oe_lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_lo_q <= '0;
            oe_lo_q <= '0;
        end else begin
            we_lo_q <= sram_we_n ? '0 : we_lo_q + 1'b1;
            oe_lo_q <= sram_oe_n ? '0 : oe_lo_q + 1'b1;
        end
    end

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && !$past(sram_ce_n)) |-> $stable(sram_addr)); // R2
    AST_ADDR_LEADS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_ce_n) |-> $stable(sram_addr)); // R2
    AST_CE2_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_ce_n |-> (sram_ce2 && sram_bs_n != '1)); // R3
    AST_RD_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_oe_n) |-> oe_lo_q == RD_FULL); // R3
    AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (we_lo_q == WE_FULL && sram_ce_n)); // R5
    AST_NO_OE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> sram_oe_n); // R6
    AST_DRV_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_we_n) |-> !sram_dq_oe); // R7
    AST_DRV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> sram_dq_oe); // R7
    AST_DRV_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |=> !sram_dq_oe); // R7
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_ce_n && sram_we_n && sram_oe_n)); // R8

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W      = 17,
    parameter int DATA_W      = 16,
    parameter int READ_CYCLES = 6,
    parameter int WE_CYCLES   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W/8-1:0] req_be,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_ce2,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [DATA_W/8-1:0] sram_bs_n,
    output logic [DATA_W-1:0] sram_dq_o,
    input  logic [DATA_W-1:0] sram_dq_i,
    output logic              sram_dq_oe
);

    localparam int LANES = DATA_W / 8;
    localparam int CNT_W = $clog2(max_int(READ_CYCLES, WE_CYCLES) + 1);

    logic [LANES-1:0]  cur_be;
    logic [LANES-1:0]  lane_strobe_n;
    logic [DATA_W-1:0] lane_rdata;
    logic              cnt_load;
    logic [CNT_W-1:0]  cnt_val;
    logic              cnt_zero;

    asram_lanes #(
        .LANES  (LANES),
        .LANE_W (8)
    ) u_lanes (
        .lane_en    (cur_be),
        .bus_in     (sram_dq_i),
        .strobe_n   (lane_strobe_n),
        .bus_masked (lane_rdata)
    );

    asram_wait_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .zero     (cnt_zero)
    );

    asram_seq #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .LANES       (LANES),
        .READ_CYCLES (READ_CYCLES),
        .WE_CYCLES   (WE_CYCLES),
        .CNT_W       (CNT_W)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_we        (req_we),
        .req_addr      (req_addr),
        .req_wdata     (req_wdata),
        .req_be        (req_be),
        .rd_data       (rd_data),
        .rd_valid      (rd_valid),
        .cur_be        (cur_be),
        .lane_strobe_n (lane_strobe_n),
        .lane_rdata    (lane_rdata),
        .cnt_load      (cnt_load),
        .cnt_val       (cnt_val),
        .cnt_zero      (cnt_zero),
        .sram_addr     (sram_addr),
        .sram_ce_n     (sram_ce_n),
        .sram_ce2      (sram_ce2),
        .sram_oe_n     (sram_oe_n),
        .sram_we_n     (sram_we_n),
        .sram_bs_n     (sram_bs_n),
        .sram_dq_o     (sram_dq_o),
        .sram_dq_oe    (sram_dq_oe)
    );

endmodule

// File: tb/tb_asram_ctrl.sv
module tb_asram_ctrl;

    localparam int RC = 6;
    localparam int WC = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_we = 1'b0;
    logic [16:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic [16:0] sram_addr;
    logic        sram_ce_n, sram_ce2, sram_oe_n, sram_we_n, sram_dq_oe;
    logic [1:0]  sram_bs_n;
    logic [15:0] sram_dq_o;
    logic [15:0] sram_dq_i = 16'hDEAD;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    asram_ctrl #(.READ_CYCLES(RC), .WE_CYCLES(WC)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rd_data(rd_data), .rd_valid(rd_valid), .sram_addr(sram_addr),
        .sram_ce_n(sram_ce_n), .sram_ce2(sram_ce2), .sram_oe_n(sram_oe_n),
        .sram_we_n(sram_we_n), .sram_bs_n(sram_bs_n), .sram_dq_o(sram_dq_o),
        .sram_dq_i(sram_dq_i), .sram_dq_oe(sram_dq_oe)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] init_word(input logic [16:0] a);
        return a[15:0] ^ {a[16], 15'h3C5A};
    endfunction

    // Memory model contents and bench reference
    logic [15:0] mdl_mem [int unsigned];
    logic [15:0] ref_mem [int unsigned];

    function automatic logic [15:0] ref_rd(input logic [16:0] a);
        if (ref_mem.exists(int'(a))) return ref_mem[int'(a)];
        return init_word(a);
    endfunction

    function automatic logic [15:0] exp_read(input logic [16:0] a, input logic [1:0] be);
        logic [15:0] w;
        w = ref_rd(a);
        return {be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00};
    endfunction

    logic [1:0]  cur_be = '0;
    logic [15:0] cur_wdata = '0;
    bit          saw_ce = 0;
    bit          prev_ce_n = 1, prev_we_n = 1, prev_oe_n = 1, we_rose = 0;
    logic [16:0] prev_addr = '0;
    int          we_lo = 0, oe_lo = 0, rd_age = 0;

    always @(negedge clk) begin
        logic [15:0] w;
        if (rst_n) begin
            if (!sram_ce_n) begin
                saw_ce = 1;
                chk(sram_addr == prev_addr, "R2 addr moved while selected", 32'(sram_addr), 32'(prev_addr));
                chk(sram_ce2 == 1'b1, "R3 ce2 with ce_n", 32'(sram_ce2), 1);
                chk(sram_bs_n == ~cur_be, "R5 strobes", 32'(sram_bs_n), 32'(~cur_be));
            end
            if (!sram_we_n) chk(sram_oe_n == 1'b1, "R6 oe during write", 32'(sram_oe_n), 1);
            if (!sram_oe_n) chk(sram_dq_oe == 1'b0, "R6 drive during read", 32'(sram_dq_oe), 0);
            if (!sram_we_n && prev_we_n) chk(!sram_dq_oe, "R7 early drive", 32'(sram_dq_oe), 0);
            if (we_rose) chk(!sram_dq_oe, "R7 release", 32'(sram_dq_oe), 0);
            if (sram_dq_oe) chk(sram_dq_o == cur_wdata, "R7 data", 32'(sram_dq_o), 32'(cur_wdata));
            if (!sram_we_n) we_lo++;
            else if (!prev_we_n) begin
                chk(we_lo == WC, "R5 we width", 32'(we_lo), WC);
                chk(sram_dq_oe, "R7 hold", 32'(sram_dq_oe), 1);
                chk(sram_ce_n && sram_bs_n == 2'b11, "R5 joint release", {sram_ce_n, sram_bs_n}, 3'b111);
                we_lo = 0;
            end
            if (!sram_oe_n) oe_lo++;
            else if (!prev_oe_n) begin
                chk(oe_lo == RC, "R3 read width", 32'(oe_lo), RC);
                oe_lo = 0;
            end
        end
        // model read path: data valid only after RC selected read clocks
        if (!sram_ce_n && sram_ce2 && !sram_oe_n && sram_we_n) rd_age = rd_age + 1;
        else rd_age = 0;
        w = mdl_mem.exists(int'(sram_addr)) ? mdl_mem[int'(sram_addr)] : init_word(sram_addr);
        sram_dq_i = 16'hDEAD;
        if (rd_age >= RC) begin
            sram_dq_i[7:0]  = sram_bs_n[0] ? 8'hA5 : w[7:0];
            sram_dq_i[15:8] = sram_bs_n[1] ? 8'hA5 : w[15:8];
        end
        // model write path
        if (!sram_ce_n && sram_ce2 && !sram_we_n && sram_dq_oe) begin
            if (!sram_bs_n[0]) w[7:0]  = sram_dq_o[7:0];
            if (!sram_bs_n[1]) w[15:8] = sram_dq_o[15:8];
            mdl_mem[int'(sram_addr)] = w;
        end
        we_rose   = sram_we_n && !prev_we_n;
        prev_ce_n = sram_ce_n;
        prev_we_n = sram_we_n;
        prev_oe_n = sram_oe_n;
        prev_addr = sram_addr;
    end

    task automatic run_op(input bit we, input logic [16:0] a, input logic [15:0] d, input logic [1:0] be);
        int n;
        int exp_n;
        logic [15:0] w;
        while (!req_ready) @(negedge clk);
        cur_be    = be;
        cur_wdata = d;
        saw_ce    = 0;
        req_valid = 1'b1;
        req_we    = we;
        req_addr  = a;
        req_wdata = d;
        req_be    = be;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        if (!we) begin
            while (!rd_valid && n < 64) begin @(negedge clk); n++; end
            exp_n = (be == 2'b00) ? 1 : RC + 2;
            chk(n == exp_n, "R8 read latency", 32'(n), 32'(exp_n));
            chk(rd_data == exp_read(a, be), "R4 read data", 32'(rd_data), 32'(exp_read(a, be)));
            @(negedge clk);
            chk(!rd_valid, "R10 valid pulse", 32'(rd_valid), 0);
        end else begin
            while (!req_ready && n < 64) begin @(negedge clk); n++; end
            exp_n = (be == 2'b00) ? 1 : WC + 3;
            chk(n == exp_n, "R8 write latency", 32'(n), 32'(exp_n));
            w = ref_rd(a);
            if (be[0]) w[7:0]  = d[7:0];
            if (be[1]) w[15:8] = d[15:8];
            ref_mem[int'(a)] = w;
        end
        if (be == 2'b00) chk(!saw_ce, "R9 no pin activity", 32'(saw_ce), 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({sram_ce_n, sram_ce2, sram_oe_n, sram_we_n, sram_bs_n, sram_dq_oe} == 7'b1011110,
            "R1 reset pins", {sram_ce_n, sram_ce2, sram_oe_n, sram_we_n, sram_bs_n, sram_dq_oe}, 7'b1011110);
        chk(req_ready && !rd_valid, "R1 reset host", {req_ready, rd_valid}, 2'b10);

        // Directed corners
        run_op(1'b0, 17'h1FFFF, 16'h0, 2'b11);       // R3 untouched top word
        run_op(1'b1, 17'h1FFFF, 16'hBEEF, 2'b11);    // R5 full write
        run_op(1'b0, 17'h1FFFF, 16'h0, 2'b11);
        run_op(1'b1, 17'h00000, 16'h1234, 2'b01);    // lower lane only
        run_op(1'b0, 17'h00000, 16'h0, 2'b11);
        run_op(1'b1, 17'h00000, 16'hABCD, 2'b10);    // upper lane only
        run_op(1'b0, 17'h00000, 16'h0, 2'b01);       // R4 upper lane zeroed
        run_op(1'b0, 17'h00000, 16'h0, 2'b10);       // R4 lower lane zeroed
        run_op(1'b0, 17'h00005, 16'h0, 2'b00);       // R9 zero read
        run_op(1'b1, 17'h00005, 16'hFFFF, 2'b00);    // R9 zero write
        run_op(1'b0, 17'h00005, 16'h0, 2'b11);       // R9 nothing written

        // Constrained random mix
        for (int i = 0; i < 400; i++) begin
            logic [16:0] a;
            int sel;
            sel = $urandom % 8;
            if (sel == 0) a = 17'h00000;
            else if (sel == 1) a = 17'h1FFFF;
            else a = 17'($urandom % 16);
            run_op(1'($urandom % 2), a, 16'($urandom), 2'($urandom % 4));
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R8 watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule